// File: doc/BRIEF.md
# Receive Byte Assembler with Interrupt Flags

This block sits between a spread-spectrum correlator channel and the register file of a radio receiver. Each time the correlator decides a bit, it strobes the bit value together with a quality flag saying whether the decision was trustworthy. The block collects these bits into a byte, filling from the least significant position upward. It also keeps a parallel mask that records which positions held trustworthy decisions.

A byte moves into the output data and mask registers in one of two cases: its last position is filled, or an end-of-frame strobe arrives while some bits are pending. Every such transfer raises a "full" flag. The block also raises an overflow flag when a byte replaces one that was never read, an underflow flag when the data register is read while empty, and an end-of-frame flag.

All flags are cleared by a single status read. A set of enable inputs selects which flags drive the shared interrupt line. Outside receive mode the block ignores incoming strobes, shows zero status and holds the interrupt low. The stored flags and the enables are kept for when receive mode returns.

Top module: `rx_serdes_irq`

## Requirements
- R1: The n-th accepted bit of a byte (n counted from 0) lands in position n of `rxData`, so the first bit received is bit 0.
- R2: The eighth accepted bit transfers the assembled byte into `rxData`/`rxValid` and sets the full flag (status bit 0), both visible after the clock edge that accepted the bit.
- R3: An end-of-frame strobe with pending bits transfers a partial byte in which positions not received read 0 in both `rxData` and `rxValid`. Any end-of-frame strobe sets status bit 1. An end-of-frame strobe with no pending bits transfers nothing and leaves `rxData` unchanged.
- R4: Bit n of `rxValid` equals the quality flag `bitQual` that came with the bit stored at position n.
- R5: A transfer into the data register while the previous byte is still unread sets the overflow flag (status bit 2). A transfer in the same cycle as a data read does not set it.
- R6: A data read (`rdDataStb`) while no unread byte is held sets the underflow flag (status bit 3).
- R7: A status read (`rdStatStb`) clears all four flags after the edge. A flag event in the same cycle as the read still leaves its flag set.
- R8: `irq` is high exactly when some status bit and the enable bit at the same position are both 1.
- R9: With `rxMode` low, `rxStatus` reads 0 and `irq` is low. Bit and end-of-frame strobes are ignored. Flags set before leaving receive mode read back again once `rxMode` returns high.
- R10: A bit strobe and an end-of-frame strobe in the same cycle store the bit first and then transfer the byte that includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rxMode | input | 1 | High while the radio is in receive mode |
| bitStb | input | 1 | A decided bit is presented this cycle |
| bitIn | input | 1 | Value of the decided bit |
| bitQual | input | 1 | The decided bit is trustworthy |
| eofStb | input | 1 | End of frame detected this cycle |
| rdDataStb | input | 1 | Register read of the data register this cycle |
| rdStatStb | input | 1 | Register read of the status register this cycle |
| intEn | input | 4 | Interrupt enables, same bit positions as the status |
| rxData | output | 8 | Received data register |
| rxValid | output | 8 | Per-position valid mask of the received byte |
| rxStatus | output | 4 | Flags: 0 full, 1 end of frame, 2 overflow, 3 underflow |
| irq | output | 1 | Receive contribution to the shared interrupt line |

## Verification
Two collisions matter most. The first is a byte transfer in the same clock as a status read: the full flag must survive the clear. The second is a byte transfer in the same clock as a data read: overflow must not be raised, because the old byte is consumed as the new one lands. The bench provokes both by asserting both read strobes together with the eighth bit strobe, while the previous byte is still unread and its full flag still set. It then expects a status of exactly full alone, with the new byte in the data register.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int STAT_W  = 4;
  localparam int ST_FULL = 0;
  localparam int ST_EOF  = 1;
  localparam int ST_OVF  = 2;
  localparam int ST_UDF  = 3;

  typedef struct packed {
    logic shiftBit;
    logic pushByte;
  } dpCtl_t;
endpackage

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CNT_W-1:0]  bitSlot,
  input  logic              bitIn,
  input  logic              bitQual,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] rxValid
);
  logic [DATA_W-1:0] asmData, asmValid;
  logic [DATA_W-1:0] nextData, nextValid;

  always_comb begin
    nextData  = asmData;
    nextValid = asmValid;
    if (ctl.shiftBit) begin
      nextData[bitSlot]  = bitIn;
      nextValid[bitSlot] = bitQual;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmData  <= '0;
      asmValid <= '0;
      rxData   <= '0;
      rxValid  <= '0;
    end else if (ctl.pushByte) begin
      rxData   <= nextData;
      rxValid  <= nextValid;
      asmData  <= '0;
      asmValid <= '0;
    end else begin
      asmData  <= nextData;
      asmValid <= nextValid;
    end
  end

  AST_ASM_EMPTY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pushByte |=> (asmData == '0 && asmValid == '0)); // R3
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxMode,
  input  logic              bitStb,
  input  logic              eofStb,
  input  logic              rdDataStb,
  input  logic              rdStatStb,
  input  logic [STAT_W-1:0] intEn,
  output dpCtl_t            ctl,
  output logic [CNT_W-1:0]  bitSlot,
  output logic [STAT_W-1:0] rxStatus,
  output logic              irq
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bitCount;
  logic              occupied;
  logic [STAT_W-1:0] flags, setVec;
  logic              acceptBit, acceptEof, lastBit, pushNow;

  assign acceptBit = rxMode & bitStb;
  assign acceptEof = rxMode & eofStb;
  assign lastBit   = acceptBit && (bitCount == LAST_SLOT);
  assign pushNow   = lastBit || (acceptEof && (acceptBit || bitCount != '0));

  always_comb begin
    ctl.shiftBit = acceptBit;
    ctl.pushByte = pushNow;
  end
  assign bitSlot = bitCount;

  always_comb begin
    setVec          = '0;
    setVec[ST_FULL] = pushNow;
    setVec[ST_EOF]  = acceptEof;
    setVec[ST_OVF]  = pushNow & occupied & ~rdDataStb;
    setVec[ST_UDF]  = rdDataStb & ~occupied;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      occupied <= 1'b0;
      flags    <= '0;
    end else begin
      if (pushNow)        bitCount <= '0;
      else if (acceptBit) bitCount <= bitCount + CNT_W'(1);
      occupied <= pushNow | (occupied & ~rdDataStb);
      flags    <= setVec | (flags & ~{STAT_W{rdStatStb}});
    end
  end

  assign rxStatus = rxMode ? flags : '0;
  assign irq      = |(rxStatus & intEn);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (acceptBit && !pushNow) |=> (bitCount == $past(bitCount) + CNT_W'(1))); // R1
  AST_FULL_ON_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    pushNow |=> flags[ST_FULL]); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pushNow && occupied && !rdDataStb) |=> flags[ST_OVF]); // R5
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataStb && !occupied) |=> flags[ST_UDF]); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatStb && !pushNow && !acceptEof && !rdDataStb) |=> (flags == '0)); // R7
  AST_QUIET_OUTSIDE_RX: assert property (@(posedge clk) disable iff (!rstN)
    !rxMode |-> !irq); // R9
  AST_HOLD_OUTSIDE_RX: assert property (@(posedge clk) disable iff (!rstN)
    !rxMode |=> $stable(bitCount)); // R9
endmodule

// File: rtl/rx_serdes_irq.sv
module rx_serdes_irq
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxMode,
  input  logic              bitStb,
  input  logic              bitIn,
  input  logic              bitQual,
  input  logic              eofStb,
  input  logic              rdDataStb,
  input  logic              rdStatStb,
  input  logic [STAT_W-1:0] intEn,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] rxValid,
  output logic [STAT_W-1:0] rxStatus,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W);

  dpCtl_t           ctl;
  logic [CNT_W-1:0] bitSlot;

  rxs_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxMode(rxMode), .bitStb(bitStb), .eofStb(eofStb),
    .rdDataStb(rdDataStb), .rdStatStb(rdStatStb), .intEn(intEn),
    .ctl(ctl), .bitSlot(bitSlot), .rxStatus(rxStatus), .irq(irq)
  );

  rxs_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitSlot(bitSlot), .bitIn(bitIn),
    .bitQual(bitQual), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: tb/test_rx_serdes_irq.sv
module test_rx_serdes_irq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, rxMode, bitStb, bitIn, bitQual, eofStb, rdDataStb, rdStatStb;
  logic [3:0] intEn, rxStatus;
  logic [7:0] rxData, rxValid;
  logic       irq;

  rx_serdes_irq i_rx_serdes_irq (
    .clk(clk), .rstN(rstN), .rxMode(rxMode), .bitStb(bitStb), .bitIn(bitIn),
    .bitQual(bitQual), .eofStb(eofStb), .rdDataStb(rdDataStb), .rdStatStb(rdStatStb),
    .intEn(intEn), .rxData(rxData), .rxValid(rxValid), .rxStatus(rxStatus), .irq(irq)
  );

  typedef struct {
    logic [7:0] d;
    logic [7:0] v;
    int         due;
  } item_t;

  item_t      expQ[$];
  int         cycleCnt = 0;
  int         nChecks = 0;
  int         nFails = 0;
  int         mCount = 0;
  logic [7:0] mData = '0;
  logic [7:0] mValid = '0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp();
    expQ.push_back('{mData, mValid, cycleCnt + 1});
    mCount = 0;
    mData  = '0;
    mValid = '0;
  endtask

  task automatic modelBit(logic b, logic q);
    if (!rxMode) return;
    mData[mCount]  = b;
    mValid[mCount] = q;
    mCount++;
    if (mCount == 8) pushExp();
  endtask

  task automatic modelEof();
    if (!rxMode) return;
    if (mCount > 0) pushExp();
  endtask

  // monitor: compare each expected byte once its transfer edge has passed
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
      item_t it;
      it = expQ.pop_front();
      check("R1", "rxData", rxData, it.d);
      check("R4", "rxValid", rxValid, it.v);
    end
  end

  task automatic sendBit(logic b, logic q, logic eof = 1'b0, logic rdS = 1'b0, logic rdD = 1'b0);
    bitStb = 1'b1; bitIn = b; bitQual = q; eofStb = eof;
    rdStatStb = rdS; rdDataStb = rdD;
    modelBit(b, q);
    if (eof) modelEof();
    @(negedge clk);
    bitStb = 1'b0; eofStb = 1'b0; rdStatStb = 1'b0; rdDataStb = 1'b0;
  endtask

  task automatic sendEof();
    eofStb = 1'b1;
    modelEof();
    @(negedge clk);
    eofStb = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] d, logic [7:0] q, logic rdS = 1'b0, logic rdD = 1'b0);
    for (int i = 0; i < 8; i++)
      sendBit(d[i], q[i], 1'b0, (i == 7) ? rdS : 1'b0, (i == 7) ? rdD : 1'b0);
  endtask

  task automatic readStatus();
    rdStatStb = 1'b1;
    @(negedge clk);
    rdStatStb = 1'b0;
  endtask

  task automatic readData();
    rdDataStb = 1'b1;
    @(negedge clk);
    rdDataStb = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; rxMode = 1'b0; bitStb = 1'b0; bitIn = 1'b0; bitQual = 1'b0;
    eofStb = 1'b0; rdDataStb = 1'b0; rdStatStb = 1'b0; intEn = '0;
    repeat (3) @(negedge clk);
    check("R2", "reset rxData", rxData, 0);
    check("R4", "reset rxValid", rxValid, 0);
    check("R7", "reset status", rxStatus, 0);
    check("R8", "reset irq", irq, 0);
    rstN = 1'b1;
    rxMode = 1'b1;
    @(negedge clk);

    // full byte, all trustworthy
    sendByte(8'hA5, 8'hFF);
    check("R2", "status after byte", rxStatus, 4'b0001);
    readStatus();
    check("R7", "status after read", rxStatus, 4'b0000);

    // mixed quality mask, then overflow by an unread byte
    readData();
    sendByte(8'h3C, 8'hF0);
    check("R5", "no overflow after read", rxStatus, 4'b0001);
    sendByte(8'h81, 8'h5A);
    check("R5", "overflow", rxStatus, 4'b0101);
    readStatus();
    check("R7", "cleared after overflow", rxStatus, 4'b0000);

    // underflow
    readData();
    check("R6", "first read no underflow", rxStatus, 4'b0000);
    readData();
    check("R6", "underflow", rxStatus, 4'b1000);
    readStatus();

    // partial byte at end of frame
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b1);
    sendEof();
    check("R3", "status partial", rxStatus, 4'b0011);
    readData();
    readStatus();
    sendEof();
    check("R3", "eof alone status", rxStatus, 4'b0010);
    check("R3", "eof alone keeps data", rxData, 8'h05);
    readStatus();

    // bit and end of frame together
    sendBit(1'b1, 1'b1);
    sendBit(1'b1, 1'b0, 1'b1);
    check("R10", "status bit+eof", rxStatus, 4'b0011);

    // interrupt enables
    intEn = 4'b0001; #1;
    check("R8", "irq full enabled", irq, 1);
    intEn = 4'b1000; #1;
    check("R8", "irq only underflow enabled", irq, 0);
    intEn = 4'b0010; #1;
    check("R8", "irq eof enabled", irq, 1);
    intEn = 4'b0000; #1;
    check("R8", "irq none enabled", irq, 0);
    @(negedge clk);
    readStatus();
    readData();

    // leaving receive mode
    sendByte(8'h5A, 8'hFF);
    rxMode = 1'b0;
    intEn = 4'b1111; #1;
    check("R9", "status outside rx", rxStatus, 0);
    check("R9", "irq outside rx", irq, 0);
    @(negedge clk);
    sendBit(1'b1, 1'b1);
    sendBit(1'b1, 1'b1);
    sendBit(1'b1, 1'b1);
    sendEof();
    check("R9", "data unchanged outside rx", rxData, 8'h5A);
    rxMode = 1'b1; #1;
    check("R9", "flags return", rxStatus, 4'b0001);
    check("R9", "irq returns", irq, 1);
    intEn = 4'b0000;
    @(negedge clk);
    readStatus();
    readData();
    sendByte(8'hC3, 8'hFF);
    check("R9", "status after return", rxStatus, 4'b0001);

    // transfer collides with status read and data read
    sendByte(8'h96, 8'h3F, 1'b1, 1'b1);
    check("R7", "full survives clear", rxStatus, 4'b0001);
    readStatus();
    check("R7", "cleared at end", rxStatus, 4'b0000);

    repeat (2) @(negedge clk);
    check("R2", "all bytes observed", expQ.size(), 0);
    finishRun();
  end
endmodule